// File: doc/BRIEF.md
# Interrupt Cause Collector with Per-Vector Throttling

This block gathers interrupt events into a 32-bit cause register and turns them into per-vector interrupt requests for a message-signalled interrupt path. Events come from hardware cause pulses, from software writes to a cause-set register, and from four general-purpose input pins. Each vector has an enable bit, a pending bit and a throttle down-counter. The counter stops back-to-back interrupts on a vector. A request stays raised until the consumer acknowledges it.

Software reaches the block through a single-cycle register port. Read data is combinational from the address. A read strobe only causes side effects, and only at the cause address. One control register sets three things: whether every interrupt goes to vector 0 or each cause goes to its own vector, whether a cause read clears every bit or only the upper "other" range, and whether software-set causes skip the throttle. The same register holds the per-pin input enables.

Top module: `intr_cause_ctrl`

## Requirements
- R1: A hardware cause pulse on bit c sets cause bit c at the next edge. Writing to offset 0 clears each cause bit written as 1. A set and a clear of the same bit in the same cycle leave the bit set.
- R2: With control bit 1 at 0, a read strobe at offset 0 returns the cause value and clears every cause bit.
- R3: With control bit 1 at 1, a read strobe at offset 0 clears only cause bits 20 to 29. All other bits keep their values.
- R4: Writing to offset 1 sets each cause bit written as 1. It acts as a software-sourced trigger for the mapped vector.
- R5: With control bit 0 at 0, every cause triggers only vector 0. With it at 1, cause bit c triggers vector c for c below 19, and bits 19 to 31 trigger vector 19.
- R6: A vector request output rises in the cycle after its trigger and holds until its acknowledge input is high for one cycle.
- R7: When a vector fires, its throttle counter loads the value at offset 5 and counts down once per cycle. A trigger that arrives while the counter is nonzero sets the pending bit. That vector then fires at the edge after the counter reaches zero.
- R8: With control bit 2 at 1, a software-set cause fires its vector at once even while the throttle counter is nonzero. With control bit 2 at 0, it waits like any other trigger.
- R9: A vector whose enable bit at offset 2 is 0 raises no request, and a trigger sets its pending bit. It fires one edge after its enable is written to 1.
- R10: Offset 3 reads the 20-bit pending array. Writing 1 to a bit clears that pending bit, and writing 0 leaves it alone. A new blocked trigger in the same cycle as a clear leaves the bit set.
- R11: General-purpose pin k raises cause bit 24+k on a rising edge, three edges after the pin rises. This happens only while control bit 4+k is 1 and its direction flag marks it as an input.
- R12: After reset all requests, cause bits, pending bits, enables, control bits and the throttle reload read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (side effects only) |
| reg_addr_i | input | 3 | Register offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |
| cause_i | input | 32 | Hardware cause pulses |
| gpi_i | input | 4 | General-purpose pins |
| gpi_in_dir_i | input | 4 | 1 = pin configured as input |
| vec_ack_i | input | 20 | Per-vector request acknowledge |
| vec_req_o | output | 20 | Per-vector interrupt request |

## Verification
The cause and pending registers can each receive a new set and a software clear in the same cycle. The bench forces both collisions. It drives a cause pulse together with a clear write to offset 0, and a blocked trigger on a masked vector together with a pending-clear write. It then reads the register back one edge later and expects the bit to be set, because setting must win. The throttle release is checked cycle by cycle. The request must stay low until the exact edge after the counter drains.

// File: rtl/intr_pkg.sv
package intr_pkg;
  typedef enum logic [2:0] {
    A_CAUSE = 3'd0,
    A_SET   = 3'd1,
    A_EN    = 3'd2,
    A_PEND  = 3'd3,
    A_CTRL  = 3'd4,
    A_THR   = 3'd5
  } reg_addr_e;

  localparam int unsigned CTRL_ROUTE  = 0;
  localparam int unsigned CTRL_NARROW = 1;
  localparam int unsigned CTRL_IMM    = 2;
  localparam int unsigned CTRL_GPI    = 4;
endpackage

// File: rtl/intr_gpi_detect.sv
module intr_gpi_detect #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  input  logic [N-1:0] is_in_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] rise_o
);
  for (genvar k = 0; k < N; k++) begin : g_pin
    logic s1_q, s2_q, prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q   <= 1'b0;
        s2_q   <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        s1_q   <= pin_i[k];
        s2_q   <= s1_q;
        prev_q <= s2_q;
      end
    end
    assign rise_o[k] = s2_q & ~prev_q & en_i[k] & is_in_i[k];

    p_rise_after_low_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o[k] |-> !prev_q);
  end
endmodule

// File: rtl/intr_cause_reg.sv
module intr_cause_reg #(
  parameter int unsigned W  = 32,
  parameter int unsigned LO = 20,
  parameter int unsigned HI = 29
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] wclr_i,
  input  logic         rdclr_i,
  input  logic         narrow_i,
  output logic [W-1:0] cause_o
);
  function automatic logic [W-1:0] range_mask();
    logic [W-1:0] m;
    m = '0;
    for (int i = LO; i <= HI; i++) m[i] = 1'b1;
    return m;
  endfunction

  localparam logic [W-1:0] RANGE = range_mask();

  logic [W-1:0] cause_q, rd_mask;

  always_comb begin
    rd_mask = '0;
    if (rdclr_i) rd_mask = narrow_i ? RANGE : '1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cause_q <= '0;
    else         cause_q <= (cause_q & ~(wclr_i | rd_mask)) | set_i;
  end

  assign cause_o = cause_q;

  p_narrow_keep_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdclr_i && narrow_i && wclr_i == '0) |=>
      ((cause_q & ~RANGE & $past(cause_q & ~RANGE)) == $past(cause_q & ~RANGE)));

  p_full_clr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdclr_i && !narrow_i && set_i == '0) |=> cause_q == '0);

  p_set_wins_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((cause_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/intr_vec_slot.sv
module intr_vec_slot #(
  parameter int unsigned THR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic             sw_trig_i,
  input  logic             imm_i,
  input  logic             en_i,
  input  logic [THR_W-1:0] reload_i,
  input  logic             ack_i,
  input  logic             pclr_i,
  output logic             req_o,
  output logic             pend_o
);
  logic             req_q, pend_q, fire, t_zero;
  logic [THR_W-1:0] timer_q;

  assign t_zero = (timer_q == '0);
  // software trigger may skip the throttle when immediate mode is on
  assign fire = (trig_i | pend_q) & en_i & ~req_q & (t_zero | (sw_trig_i & imm_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= 1'b0;
      pend_q  <= 1'b0;
      timer_q <= '0;
    end else begin
      if (fire)       req_q <= 1'b1;
      else if (ack_i) req_q <= 1'b0;

      if (fire)        pend_q <= 1'b0;
      else if (trig_i) pend_q <= 1'b1;
      else if (pclr_i) pend_q <= 1'b0;

      if (fire)         timer_q <= reload_i;
      else if (!t_zero) timer_q <= timer_q - 1'b1;
    end
  end

  assign req_o  = req_q;
  assign pend_o = pend_q;

  p_req_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && !ack_i) |=> req_q);

  p_ack_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && ack_i) |=> !req_q);

  p_throttle_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_q) |-> ($past(t_zero) || $past(sw_trig_i && imm_i)));

  p_timer_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_q) |-> timer_q == $past(reload_i));

  p_mask_pend_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_i && !en_i) |=> (pend_q && !$rose(req_q)));
endmodule

// File: rtl/intr_cause_ctrl.sv
module intr_cause_ctrl
  import intr_pkg::*;
#(
  parameter int unsigned CAUSE_W  = 32,
  parameter int unsigned NUM_VEC  = 20,
  parameter int unsigned NUM_GPI  = 4,
  parameter int unsigned THR_W    = 8,
  parameter int unsigned OTHER_LO = 20,
  parameter int unsigned OTHER_HI = 29,
  parameter int unsigned GPI_BASE = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_wr_i,
  input  logic               reg_rd_i,
  input  logic [2:0]         reg_addr_i,
  input  logic [CAUSE_W-1:0] reg_wdata_i,
  output logic [CAUSE_W-1:0] reg_rdata_o,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [NUM_GPI-1:0] gpi_i,
  input  logic [NUM_GPI-1:0] gpi_in_dir_i,
  input  logic [NUM_VEC-1:0] vec_ack_i,
  output logic [NUM_VEC-1:0] vec_req_o
);
  localparam int unsigned CTRL_W = CTRL_GPI + NUM_GPI;
  localparam int unsigned LAST_V = NUM_VEC - 1;

  logic [CTRL_W-1:0]  ctrl_q;
  logic [NUM_VEC-1:0] en_q, pend, pclr, vtrig, vsw;
  logic [THR_W-1:0]   thr_q;
  logic [NUM_GPI-1:0] gpi_rise;
  logic [CAUSE_W-1:0] cause, sw_set, hw_set, wclr;
  logic               route, narrow, imm, rdclr;

  assign route  = ctrl_q[CTRL_ROUTE];
  assign narrow = ctrl_q[CTRL_NARROW];
  assign imm    = ctrl_q[CTRL_IMM];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      en_q   <= '0;
      thr_q  <= '0;
    end else if (reg_wr_i) begin
      case (reg_addr_i)
        A_CTRL:  ctrl_q <= reg_wdata_i[CTRL_W-1:0];
        A_EN:    en_q   <= reg_wdata_i[NUM_VEC-1:0];
        A_THR:   thr_q  <= reg_wdata_i[THR_W-1:0];
        default: ;
      endcase
    end
  end

  intr_gpi_detect #(.N(NUM_GPI)) u_gpi (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pin_i   (gpi_i),
    .is_in_i (gpi_in_dir_i),
    .en_i    (ctrl_q[CTRL_W-1:CTRL_GPI]),
    .rise_o  (gpi_rise)
  );

  assign sw_set = (reg_wr_i && reg_addr_i == A_SET)   ? reg_wdata_i : '0;
  assign wclr   = (reg_wr_i && reg_addr_i == A_CAUSE) ? reg_wdata_i : '0;
  assign pclr   = (reg_wr_i && reg_addr_i == A_PEND)  ? reg_wdata_i[NUM_VEC-1:0] : '0;
  assign rdclr  = reg_rd_i && reg_addr_i == A_CAUSE;
  assign hw_set = cause_i | (CAUSE_W'(gpi_rise) << GPI_BASE);

  intr_cause_reg #(.W(CAUSE_W), .LO(OTHER_LO), .HI(OTHER_HI)) u_cause (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (hw_set | sw_set),
    .wclr_i   (wclr),
    .rdclr_i  (rdclr),
    .narrow_i (narrow),
    .cause_o  (cause)
  );

  function automatic int unsigned vec_of(int unsigned c, logic per_vec);
    if (!per_vec)   return 0;
    if (c < LAST_V) return c;
    return LAST_V;
  endfunction

  always_comb begin
    vtrig = '0;
    vsw   = '0;
    for (int unsigned c = 0; c < CAUSE_W; c++) begin
      if (hw_set[c] | sw_set[c]) vtrig[vec_of(c, route)] = 1'b1;
      if (sw_set[c])             vsw[vec_of(c, route)]   = 1'b1;
    end
  end

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    intr_vec_slot #(.THR_W(THR_W)) u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .trig_i    (vtrig[v]),
      .sw_trig_i (vsw[v]),
      .imm_i     (imm),
      .en_i      (en_q[v]),
      .reload_i  (thr_q),
      .ack_i     (vec_ack_i[v]),
      .pclr_i    (pclr[v]),
      .req_o     (vec_req_o[v]),
      .pend_o    (pend[v])
    );
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_CAUSE: reg_rdata_o = cause;
      A_EN:    reg_rdata_o[NUM_VEC-1:0] = en_q;
      A_PEND:  reg_rdata_o[NUM_VEC-1:0] = pend;
      A_CTRL:  reg_rdata_o[CTRL_W-1:0]  = ctrl_q;
      A_THR:   reg_rdata_o[THR_W-1:0]   = thr_q;
      default: ;
    endcase
  end

  p_single_vec_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !route |=> ((vec_req_o[NUM_VEC-1:1] & ~$past(vec_req_o[NUM_VEC-1:1])) == '0));

  p_pend_w1c_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pclr != '0 && vtrig == '0) |=> ((pend & $past(pclr)) == '0));
endmodule

// File: tb/test_intr_cause_ctrl.sv
module test_intr_cause_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 20;
  localparam int WD = 100000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata, cause = '0;
  logic [3:0]  gpi = '0, gpi_dir = '0;
  logic [NV-1:0] ack = '0, req;
  int nchk = 0, nerr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intr_cause_ctrl i_intr_cause_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .cause_i(cause), .gpi_i(gpi), .gpi_in_dir_i(gpi_dir),
    .vec_ack_i(ack), .vec_req_o(req)
  );

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic peek(logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic pulse(logic [31:0] m);
    cause = m; tick(); cause = '0;
  endtask

  task automatic cleanup();
    wr(3'd2, '0);
    ack = '1; tick(); ack = '0;
    wr(3'd3, '1);
    wr(3'd0, '1);
    wr(3'd5, '0);
    repeat (260) tick();
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 6; a++) begin
      peek(3'(a), d); check("R12 reg after reset", d, '0);
    end
    check("R12 req after reset", 32'(req), '0);
  endtask

  task automatic t_cause_reg();
    logic [31:0] d;
    wr(3'd4, 32'h1);
    pulse(32'h2030_0001);
    peek(3'd0, d); check("R1 cause set", d, 32'h2030_0001);
    wr(3'd0, 32'h0000_0001);
    peek(3'd0, d); check("R1 w1c", d, 32'h2030_0000);
    cause = 32'h4; reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h4;
    tick(); cause = '0; reg_wr = 1'b0;
    peek(3'd0, d); check("R1 set beats clear", d, 32'h2030_0004);
    wr(3'd1, 32'h8000_0000);
    peek(3'd0, d); check("R4 sw set", d, 32'hA030_0004);
    wr(3'd4, 32'h3);
    reg_rd = 1'b1; reg_addr = 3'd0; #1; d = reg_rdata; tick(); reg_rd = 1'b0;
    check("R3 read value", d, 32'hA030_0004);
    peek(3'd0, d); check("R3 narrow clear", d, 32'h8000_0004);
    wr(3'd4, 32'h1);
    reg_rd = 1'b1; reg_addr = 3'd0; tick(); reg_rd = 1'b0;
    peek(3'd0, d); check("R2 full clear", d, '0);
    cleanup();
  endtask

  task automatic t_routing();
    wr(3'd2, '1); wr(3'd4, 32'h0);
    pulse(32'h20);
    check("R5 mode0 vec0", 32'(req[0]), 1);
    check("R5 mode0 no vec5", 32'(req[5]), 0);
    ack[0] = 1'b1; tick(); ack[0] = 1'b0;
    check("R6 ack drops", 32'(req[0]), 0);
    wr(3'd4, 32'h1);
    pulse(32'h0200_0000);
    check("R5 mode1 upper to vec19", 32'(req), 32'h8_0000);
    pulse(32'h20);
    check("R5 mode1 bit5", 32'(req), 32'h8_0020);
    repeat (3) tick();
    check("R6 held without ack", 32'(req), 32'h8_0020);
    cleanup();
  endtask

  task automatic t_throttle();
    logic [31:0] d;
    wr(3'd2, '1); wr(3'd4, 32'h1); wr(3'd5, 32'd4);
    pulse(32'h8);
    check("R7 first fire", 32'(req[3]), 1);
    ack[3] = 1'b1; tick(); ack[3] = 1'b0;
    pulse(32'h8);
    check("R7 blocked", 32'(req[3]), 0);
    peek(3'd3, d); check("R7 pending set", d, 32'h8);
    tick(); check("R7 still blocked t1", 32'(req[3]), 0);
    tick(); check("R7 still blocked t0", 32'(req[3]), 0);
    tick(); check("R7 release edge", 32'(req[3]), 1);
    peek(3'd3, d); check("R7 pending cleared", d, 0);
    cleanup();
  endtask

  task automatic t_immediate();
    logic [31:0] d;
    wr(3'd2, '1); wr(3'd4, 32'h5); wr(3'd5, 32'd6);
    wr(3'd1, 32'h80);
    check("R8 first sw fire", 32'(req[7]), 1);
    ack[7] = 1'b1; tick(); ack[7] = 1'b0;
    wr(3'd1, 32'h80);
    check("R8 imm bypass", 32'(req[7]), 1);
    ack[7] = 1'b1; tick(); ack[7] = 1'b0;
    wr(3'd4, 32'h1);
    wr(3'd1, 32'h80);
    check("R8 no imm waits", 32'(req[7]), 0);
    peek(3'd3, d); check("R8 pending", d, 32'h80);
    repeat (3) tick();
    check("R8 before expiry", 32'(req[7]), 0);
    tick();
    check("R8 fires on expiry", 32'(req[7]), 1);
    cleanup();
  endtask

  task automatic t_mask_pend();
    logic [31:0] d;
    wr(3'd4, 32'h1); wr(3'd2, 32'(~(20'h200 | 20'h400)));
    pulse(32'h200);
    check("R9 masked no req", 32'(req[9]), 0);
    peek(3'd3, d); check("R9 pending", d, 32'h200);
    wr(3'd2, '1);
    check("R9 not before enable seen", 32'(req[9]), 0);
    tick();
    check("R9 fires after enable", 32'(req[9]), 1);
    wr(3'd2, 32'(~20'h400));
    pulse(32'h400);
    wr(3'd3, 32'h0);
    peek(3'd3, d); check("R10 write0 no effect", d, 32'h400);
    wr(3'd3, 32'h400);
    peek(3'd3, d); check("R10 w1c", d, 32'h0);
    cause = 32'h400; reg_wr = 1'b1; reg_addr = 3'd3; reg_wdata = 32'h400;
    tick(); cause = '0; reg_wr = 1'b0;
    peek(3'd3, d); check("R10 set beats clear", d, 32'h400);
    cleanup();
  endtask

  task automatic t_gpi();
    logic [31:0] d;
    wr(3'd0, '1);
    wr(3'd4, 32'h31);        // pin0 and pin1 enabled, pin2 not
    gpi_dir = 4'b0110;       // pin0 output, pins 1 and 2 inputs
    gpi = 4'b0111;
    tick(); tick();
    peek(3'd0, d); check("R11 not yet", d, 0);
    tick();
    peek(3'd0, d); check("R11 pin1 after 3 edges", d, 32'h0200_0000);
    repeat (3) tick();
    peek(3'd0, d); check("R11 disabled/output pins ignored", d, 32'h0200_0000);
    gpi = '0; gpi_dir = '0;
    cleanup();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_cause_reg();
    t_routing();
    t_throttle();
    t_immediate();
    t_mask_pend();
    t_gpi();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (WD) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog act=running exp=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule